// File: doc/BRIEF.md
# Equalizer Boost Configuration Chain

This block holds the boost settings for four equalizer channels. A 21-bit shift chain is loaded over a simple serial bus made of a clock, a data input and an active-low enable. One bit of the chain is a source flag. The other twenty bits form four 5-bit boost words, one for each channel. While the flag is clear, each channel instead takes its boost level from three strap inputs. Each strap input carries one base-3 digit, and the three digits together index a lookup of 27 boost levels.

The last stage of the chain drives a serial output, so several of these blocks can be linked into one long chain and loaded from a single host port. A mode input clears the whole chain when it is low, and while it is low the strapped levels are always used. At reset every stage is zero, so a board works from its strap settings until a host loads the chain, if it ever does.

Top module: `eqcfg_boost_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `sclk` edge) clears all 21 chain stages. After that edge `sdo` is 0 and every channel shows its strapped level.
- R2: While chain stage 1 (the source flag) is 0, each channel's `boost` equals its strapped level, whatever the other 20 stages hold.
- R3: Each channel has three 2-bit strap codes packed as {A, B, C} in bits [6c+5:6c], where c is the channel index from 0. A is the most significant base-3 digit and C the least. The code values 0, 1 and 2 are the digit values, and code 3 reads as digit 0.
- R4: A strap value v in 0..26 maps to the boost level floor((31*v + 13) / 26). The map runs from 0 at v=0 to 31 at v=26 and never decreases.
- R5: A rising `sclk` edge shifts the chain only when `sen_n` is low and `mode` is high. While `sen_n` is high and `mode` is high, every stage holds its value and so does `sdo`.
- R6: `sdo` shows stage 1. A bit captured on the n-th shifting edge reaches `sdo` after the (n+20)-th shifting edge, which is a 21-clock delay from `sdi` to `sdo`.
- R7: Bits enter at stage 21 and move toward stage 1. After 21 shifts the first bit sent is the flag. Channel c (counting from 0) holds stages 2+5c to 6+5c, with the most significant bit in the lowest-numbered stage. When the flag is 1 and `mode` is high, `boost` for channel c equals that word.
- R8: While `mode` is low, `boost` shows the strapped levels in the same cycle, and a rising edge clears every chain stage.
- R9: `boost` follows changes on `ctl_trits` and on chain contents combinationally, with no extra register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | High allows serial loading; low clears the chain and forces strapped levels |
| sen_n | input | 1 | Active-low shift enable |
| sdi | input | 1 | Serial data in, entering at stage 21 |
| ctl_trits | input | 24 | Four channels of three 2-bit strap codes, channel c at [6c+5:6c] in the order A, B, C |
| sdo | output | 1 | Serial data out from stage 1, used for daisy-chaining |
| boost | output | 20 | Four 5-bit boost levels, channel c at [5c+4:5c] |

## Verification
The bench builds the block with its default parameters: four channels, 5-bit levels and three strap digits. These defaults keep the strap space at only 27 values per channel. The sweep therefore covers every strap value on every channel, with the unused code 3 mixed in, and compares each result against the arithmetic map. Because the chain is only 21 stages long, the bench can load complete frames with extreme and mixed words and follow a long bit stream through the chain, with hold gaps in it, bit by bit at `sdo`. Frames are also sent with the flag clear, and `mode` is dropped in the middle of a run.

// File: rtl/eqcfg_pkg.sv
`timescale 1ns/1ps
package eqcfg_pkg;

    localparam int NUM_CH_DEF = 4;
    localparam int LVL_W_DEF  = 5;
    localparam int DIGITS_DEF = 3;
    localparam int TRIT_W     = 2;

    typedef enum logic {
        SRC_PINS  = 1'b0,
        SRC_CHAIN = 1'b1
    } src_e;

    // Decodes a 2-bit strap code into a digit value; the unused code 3 reads as 0.
    function automatic int trit_value(logic [TRIT_W-1:0] code);
        return (code == 2'd3) ? 0 : int'(code);
    endfunction

    // Scales a strap value onto the level range with rounding; the result never decreases as v grows.
    function automatic int tern_to_level(int v, int v_max, int lvl_max);
        return (v * lvl_max + v_max / 2) / v_max;
    endfunction

endpackage

// File: rtl/eqcfg_shift_chain.sv
`timescale 1ns/1ps
module eqcfg_shift_chain #(
    parameter int LEN = 21
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_i,
    input  logic         en_n_i,
    input  logic         sdi_i,
    output logic [LEN:1] regs_o,
    output logic         sdo_o
);
    logic [LEN:1] chain_q;

    // New bits enter at stage LEN and move toward stage 1.
    always_ff @(posedge clk) begin
        if (rst || !mode_i) begin
            chain_q <= '0;
        end else if (!en_n_i) begin
            chain_q <= {sdi_i, chain_q[LEN:2]};
        end
    end

    assign regs_o = chain_q;
    assign sdo_o  = chain_q[1];

    // R5: with the enable high and mode high, the output stage holds
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (en_n_i && mode_i) |=> $stable(sdo_o));

    // R8: mode low clears the chain at the next edge
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (!mode_i) |=> (regs_o == '0));

    // R6: a shifting edge moves stage 2 onto the output
    a_r6_advance: assert property (@(posedge clk) disable iff (rst)
        (mode_i && !en_n_i) |=> (sdo_o == $past(regs_o[2])));

endmodule

// File: rtl/eqcfg_trit_decode.sv
`timescale 1ns/1ps
module eqcfg_trit_decode
    import eqcfg_pkg::*;
#(
    parameter int DIGITS = 3,
    parameter int LVL_W  = 5
) (
    input  logic [DIGITS*TRIT_W-1:0] trits_i,
    output logic [LVL_W-1:0]         level_o
);
    localparam int V_MAX   = 3**DIGITS - 1;
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    int acc;

    always_comb begin
        acc = 0;
        // The top digit (pin A) is folded in first.
        for (int d = DIGITS - 1; d >= 0; d--) begin
            acc = acc * 3 + trit_value(trits_i[d*TRIT_W +: TRIT_W]);
        end
        level_o = LVL_W'(tern_to_level(acc, V_MAX, LVL_MAX));
    end

endmodule

// File: rtl/eqcfg_level_select.sv
`timescale 1ns/1ps
module eqcfg_level_select
    import eqcfg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LVL_W  = 5,
    parameter int LEN    = 21
) (
    input  src_e                    src_i,
    input  logic [LEN:1]            regs_i,
    input  logic [NUM_CH*LVL_W-1:0] pin_lvls_i,
    output logic [NUM_CH*LVL_W-1:0] boost_o
);
    logic [NUM_CH*LVL_W-1:0] stored;

    // Channel c sits in stages 2+LVL_W*c and up, most significant bit first.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar i = 0; i < LVL_W; i++) begin : g_bit
            assign stored[c*LVL_W + LVL_W-1-i] = regs_i[2 + LVL_W*c + i];
        end
    end

    always_comb begin
        boost_o = (src_i == SRC_CHAIN) ? stored : pin_lvls_i;
    end

endmodule

// File: rtl/eqcfg_boost_ctrl.sv
`timescale 1ns/1ps
module eqcfg_boost_ctrl
    import eqcfg_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int LVL_W  = LVL_W_DEF,
    parameter int DIGITS = DIGITS_DEF
) (
    input  logic                           sclk,
    input  logic                           rst,
    input  logic                           mode,
    input  logic                           sen_n,
    input  logic                           sdi,
    input  logic [NUM_CH*DIGITS*TRIT_W-1:0] ctl_trits,
    output logic                           sdo,
    output logic [NUM_CH*LVL_W-1:0]        boost
);
    localparam int LEN   = 1 + NUM_CH * LVL_W;
    localparam int CH_TW = DIGITS * TRIT_W;

    logic [LEN:1]            regs;
    logic [NUM_CH*LVL_W-1:0] pin_lvls;
    src_e                    src;

    eqcfg_shift_chain #(.LEN(LEN)) u_chain (
        .clk    (sclk),
        .rst    (rst),
        .mode_i (mode),
        .en_n_i (sen_n),
        .sdi_i  (sdi),
        .regs_o (regs),
        .sdo_o  (sdo)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        eqcfg_trit_decode #(.DIGITS(DIGITS), .LVL_W(LVL_W)) u_dec (
            .trits_i (ctl_trits[c*CH_TW +: CH_TW]),
            .level_o (pin_lvls[c*LVL_W +: LVL_W])
        );
    end

    assign src = (mode && regs[1]) ? SRC_CHAIN : SRC_PINS;

    eqcfg_level_select #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .LEN(LEN)) u_sel (
        .src_i      (src),
        .regs_i     (regs),
        .pin_lvls_i (pin_lvls),
        .boost_o    (boost)
    );

    // R2: a clear flag gives the strapped levels
    a_r2_flag_clear: assert property (@(posedge sclk) disable iff (rst)
        (!regs[1]) |-> (boost == pin_lvls));

    // R8: mode low gives the strapped levels
    a_r8_mode_low: assert property (@(posedge sclk) disable iff (rst)
        (!mode) |-> (boost == pin_lvls));

    // R7: channel 0 takes its most significant bit from stage 2
    a_r7_ch0_msb: assert property (@(posedge sclk) disable iff (rst)
        (mode && regs[1]) |-> (boost[LVL_W-1] == regs[2]));

    // R1: after reset the output stage is empty
    a_r1_reset: assert property (@(posedge sclk)
        rst |=> (sdo == 1'b0));

endmodule

// File: tb/eqcfg_boost_ctrl_bench.sv
`timescale 1ns/1ps
module eqcfg_boost_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst, mode, sen_n, sdi;
    logic [23:0] ctl_trits;
    logic        sdo;
    logic [19:0] boost;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    eqcfg_boost_ctrl u_eqcfg_boost_ctrl (
        .sclk(clk), .rst(rst), .mode(mode), .sen_n(sen_n), .sdi(sdi),
        .ctl_trits(ctl_trits), .sdo(sdo), .boost(boost)
    );

    function automatic int exp_level(int v);
        return (31 * v + 13) / 26;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Encodes a strap value as three codes; a zero digit is written as code 3 when alt is set.
    function automatic logic [5:0] enc(int v, bit alt);
        logic [5:0] r;
        int d [3];
        d[0] = v / 9; d[1] = (v / 3) % 3; d[2] = v % 3;
        for (int k = 0; k < 3; k++) begin
            r[5-2*k -: 2] = (d[k] == 0 && alt) ? 2'd3 : 2'(d[k]);
        end
        return r;
    endfunction

    task automatic shift_bit(logic b);
        @(negedge clk); sdi = b; sen_n = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic send_frame(logic flag, logic [19:0] words);
        shift_bit(flag);
        for (int c = 0; c < 4; c++)
            for (int i = 4; i >= 0; i--) shift_bit(words[c*5 + i]);
        @(negedge clk); sen_n = 1'b1;
    endtask

    task automatic set_straps(int v0, int v1, int v2, int v3);
        ctl_trits = {enc(v3, 1'b0), enc(v2, 1'b1), enc(v1, 1'b0), enc(v0, 1'b1)};
        #1;
    endtask

    task automatic check_pins(string req, int v0, int v1, int v2, int v3);
        chk(req, int'(boost[4:0]),   exp_level(v0));
        chk(req, int'(boost[9:5]),   exp_level(v1));
        chk(req, int'(boost[14:10]), exp_level(v2));
        chk(req, int'(boost[19:15]), exp_level(v3));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [19:0] w;
        logic        hist [64];
        int          nsh;
        rst = 1'b1; mode = 1'b1; sen_n = 1'b0; sdi = 1'b1;
        set_straps(5, 0, 26, 13);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; sen_n = 1'b1; sdi = 1'b0;
        #1;
        // R1 reset state
        chk("R1 sdo", int'(sdo), 0);
        check_pins("R1 levels", 5, 0, 26, 13);

        // R3 R4: every strap value on every channel, code 3 mixed in
        for (int v = 0; v < 27; v++) begin
            set_straps(v, (v + 7) % 27, (v + 14) % 27, 26 - v);
            check_pins("R3/R4 sweep", v, (v + 7) % 27, (v + 14) % 27, 26 - v);
        end
        // R4 end points and monotonic map
        set_straps(0, 26, 1, 25);
        check_pins("R4 ends", 0, 26, 1, 25);
        chk("R4 min", int'(boost[4:0]), 0);
        chk("R4 max", int'(boost[9:5]), 31);

        // R7: load chain words with the flag set
        w = {5'd31, 5'd0, 5'd17, 5'd9};
        send_frame(1'b1, w);
        chk("R7 ch0", int'(boost[4:0]), 9);
        chk("R7 ch1", int'(boost[9:5]), 17);
        chk("R7 ch2", int'(boost[14:10]), 0);
        chk("R7 ch3", int'(boost[19:15]), 31);
        // R9: strap changes do not move chain-sourced levels; after the load sdo shows the flag
        set_straps(3, 3, 3, 3);
        chk("R7 ch0 stays", int'(boost[4:0]), 9);
        chk("R6 flag at sdo", int'(sdo), 1);

        // R5: enable high holds everything
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); sen_n = 1'b1; sdi = k[0];
            @(posedge clk); #1;
            chk("R5 hold sdo", int'(sdo), 1);
            chk("R5 hold word", int'(boost), int'(w));
        end

        // R7 second pattern
        w = {5'd1, 5'd30, 5'd21, 5'd10};
        send_frame(1'b1, w);
        chk("R7 pattern2", int'(boost), int'(w));

        // R2: flag clear with non-zero words gives straps
        send_frame(1'b0, 20'hFFFFF);
        set_straps(4, 11, 19, 22);
        check_pins("R2 flag clear", 4, 11, 19, 22);

        // R8: mode low forces straps in the same cycle, then clears the chain
        send_frame(1'b1, 20'h5A5A5);
        chk("R7 pattern3", int'(boost), 20'h5A5A5);
        @(negedge clk); mode = 1'b0; #1;
        check_pins("R8 same cycle", 4, 11, 19, 22);
        @(posedge clk); #1;
        @(negedge clk); mode = 1'b1; #1;
        chk("R8 cleared sdo", int'(sdo), 0);
        check_pins("R8 after clear", 4, 11, 19, 22);
        // R9: combinational strap follow
        set_straps(26, 26, 26, 26);
        check_pins("R9 comb", 26, 26, 26, 26);

        // R8: chain empty after clear, 21 zero shifts keep sdo at 0
        for (int k = 0; k < 21; k++) begin
            shift_bit(1'b0);
            chk("R8 empty chain", int'(sdo), 0);
        end

        // R6: bit stream with hold gaps; sdo after shift n equals bit n-20
        nsh = 0;
        for (int k = 0; k < 60; k++) begin
            logic b;
            b = (((k * 5 + 3) % 7) < 3) || (k % 11 == 0);
            hist[k] = b;
            shift_bit(b);
            chk("R6 delay", int'(sdo), (k >= 20) ? int'(hist[k-20]) : 0);
            if (k % 9 == 4) begin
                @(negedge clk); sen_n = 1'b1; sdi = ~b;
                @(posedge clk); #1;
                chk("R5 gap", int'(sdo), (k >= 20) ? int'(hist[k-20]) : 0);
            end
            nsh++;
        end
        chk("R6 count", nsh, 60);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule